// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block is the host end of a two-wire PS/2 link to a keyboard or mouse. The device drives the clock. Each device-to-host frame has a start bit of 0, eight data bits sent least significant bit first, an odd parity bit and a stop bit of 1. The controller samples each bit on a falling edge of the device clock. A frame that passes its checks is placed in a one-byte receive holding register.

To send a byte to the device, the host first inhibits the link by holding the clock low for a programmed number of ticks. It then pulls data low and releases the clock. After that it presents one bit on each falling edge of the device clock: the data bits, then the parity bit. It releases data for the stop bit and, in the standard mode, waits one more clock for the device's acknowledge.

Both lines are open-drain. The block never drives a high level. It only asserts an output-enable that pulls its line low. Both inputs pass through a synchroniser and a glitch filter. The filter runs on an internal tick equal to the reference clock divided by (divisor + 1). Software uses a byte-wide register port with five registers. Software can force either line low, read the live line levels, and enable a receive interrupt and a transmit interrupt separately.

Register access is a single-cycle strobe that is always accepted, so there is no back-pressure on the register port. The outgoing byte stream is paced by the transmit-empty flag instead. A data write made while the transmitter is occupied is dropped, not stalled. Incoming bytes are paced by the receive-full flag. A frame that completes while the previous byte is unread is dropped.

Top module: `ps2_host_port`

## Requirements
- R1: The internal tick fires once every (DIV+1) reference cycles, where DIV is the 4-bit value at address 3. The transmit inhibit phase (clock driven low, data not driven) therefore lasts INHIBIT_TICKS × (DIV+1) cycles, give or take one tick period.
- R2: Control register bit 0 (address 0) drives the clock output-enable and bit 1 drives the data output-enable, whatever the rest of the block is doing.
- R3: The status register (address 1) reads bit 0 = filtered data level, bit 1 = filtered clock level, bit 2 = parity bit of the last accepted byte, bit 3 = receive in progress, bit 4 = receive full, bit 5 = transmit busy, bit 6 = transmit empty, bit 7 = 0. An enabled, idle port on released lines reads 0x43.
- R4: A frame with start 0, eight data bits LSB first, a correct odd parity bit and stop 1 loads the byte into the data register (address 2), sets receive full and records its parity bit.
- R5: A frame with wrong parity or a stop bit of 0 is discarded: receive full stays clear.
- R6: Reading address 2 clears receive full. A frame that completes while receive full is set is dropped, and the earlier byte is kept.
- R7: Writing address 2 while transmit is empty starts a transmission. The clock is held low for the inhibit phase, then data is held low with the clock still low for one tick, then the clock is released. The data bits LSB first, the odd parity bit and a released stop bit (1) follow, each set on a falling device-clock edge.
- R8: With control bit 5 clear, the transmission completes on the 11th falling edge (the acknowledge). With bit 5 set, there is no acknowledge bit and it completes on the 10th.
- R9: A write to address 2 while transmit is not empty is ignored. The byte in flight is unchanged and no second transmission follows.
- R10: The receive interrupt equals receive full AND control bit 4, and the transmit interrupt equals transmit empty AND control bit 3. Address 4 reads them as bit 0 (receive) and bit 1 (transmit).
- R11: With control bit 2 (port enable) clear, no frame is received, a data write starts nothing, and any transmission in progress is abandoned on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register address: 0 control, 1 status, 2 data, 3 divisor, 4 interrupt |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the access |
| ps2_clk_i | input | 1 | Clock line level |
| ps2_data_i | input | 1 | Data line level |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_data_oe | output | 1 | 1 pulls the data line low |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The bound checker watches the following on every cycle:
- The force bits always reach their output-enables.
- The clock or data line is pulled low outside a force only while a transmission is active.
- Each interrupt is raised only while its enable bit is set.
- A data read always empties the receive holding register.
- Clearing the port enable always idles the transmitter.

Only the bench scenarios can show the following:
- The bit order and parity of frames in both directions.
- Rejection of bad-parity and bad-stop frames.
- The kept-byte behaviour when the receive register is full.
- The 10-edge versus 11-edge completion.
- The dropped second write.
- The inhibit length across all sixteen divisor values.

// File: rtl/ps2hp_pkg.sv
package ps2hp_pkg;
  localparam int DIV_W  = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd2;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd3;
  localparam logic [ADDR_W-1:0] A_IRQ  = 3'd4;

  // control bit positions (software decodes these)
  localparam int C_FCLK  = 0;
  localparam int C_FDAT  = 1;
  localparam int C_EN    = 2;
  localparam int C_TXIE  = 3;
  localparam int C_RXIE  = 4;
  localparam int C_NOACK = 5;
  localparam int CTRL_W  = 6;

  typedef enum logic [1:0] {TX_IDLE, TX_INHIBIT, TX_REQ, TX_SHIFT} tx_state_e;
endpackage

// File: rtl/ps2hp_tick.sv
module ps2hp_tick
  import ps2hp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ps2hp_filter.sv
module ps2hp_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_in,
  output logic line_out
);
  localparam int CW = $clog2(FILT_LEN + 1);
  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync     <= 2'b11;
      line_out <= 1'b1;
      cnt      <= '0;
    end else begin
      sync <= {sync[0], line_in};
      if (sync[1] == line_out) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == CW'(FILT_LEN - 1)) begin
          line_out <= sync[1];
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ps2hp_rx.sv
module ps2hp_rx
  import ps2hp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              fall,
  input  logic              line_data,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_par,
  output logic              rx_done,
  output logic              rx_busy
);
  logic [3:0]      bitcnt;
  logic [DATA_W:0] shreg;   // parity at top, data below

  assign rx_busy = (bitcnt != 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt  <= '0;
      shreg   <= '0;
      rx_byte <= '0;
      rx_par  <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (!active) begin
        bitcnt <= '0;
      end else if (fall) begin
        if (bitcnt == 4'd0) begin
          if (!line_data) bitcnt <= 4'd1;
        end else if (bitcnt == 4'd10) begin
          bitcnt  <= '0;
          rx_byte <= shreg[DATA_W-1:0];
          rx_par  <= shreg[DATA_W];
          rx_done <= line_data && (^shreg);
        end else begin
          shreg  <= {line_data, shreg[DATA_W:1]};
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ps2hp_tx.sv
module ps2hp_tx
  import ps2hp_pkg::*;
#(
  parameter int INHIBIT_TICKS = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              tick,
  input  logic              fall,
  input  logic              start,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              no_ack,
  output logic              busy,
  output logic              clk_drv,
  output logic              data_drv
);
  localparam int CW = $clog2(INHIBIT_TICKS + 1);
  tx_state_e       state;
  logic [CW-1:0]   cnt;
  logic [3:0]      ecnt;
  logic [DATA_W+1:0] frame;  // {stop, parity, data}
  logic            dout;

  assign busy     = (state != TX_IDLE);
  assign clk_drv  = (state == TX_INHIBIT) || (state == TX_REQ);
  assign data_drv = (state == TX_REQ) || ((state == TX_SHIFT) && !dout);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      cnt   <= '0;
      ecnt  <= '0;
      frame <= '0;
      dout  <= 1'b1;
    end else if (!active) begin
      state <= TX_IDLE;
      dout  <= 1'b1;
    end else begin
      case (state)
        TX_IDLE: if (start) begin
          frame <= {1'b1, ~^byte_in, byte_in};
          cnt   <= '0;
          state <= TX_INHIBIT;
        end
        TX_INHIBIT: if (tick) begin
          if (cnt == CW'(INHIBIT_TICKS - 1)) state <= TX_REQ;
          else                               cnt   <= cnt + 1'b1;
        end
        TX_REQ: if (tick) begin
          state <= TX_SHIFT;
          ecnt  <= '0;
          dout  <= 1'b0;
        end
        TX_SHIFT: if (fall) begin
          ecnt <= ecnt + 1'b1;
          if (ecnt < 4'd10) dout <= frame[ecnt];
          if ((ecnt == 4'd9 && no_ack) || ecnt == 4'd10) begin
            state <= TX_IDLE;
            dout  <= 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port
  import ps2hp_pkg::*;
#(
  parameter int FILT_LEN      = 4,
  parameter int INHIBIT_TICKS = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ps2_clk_i,
  input  logic              ps2_data_i,
  output logic              ps2_clk_oe,
  output logic              ps2_data_oe,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] rx_data_q;
  logic              rx_full_q, rx_par_q, clk_prev;
  logic              tick, fall, en;
  logic [1:0]        line_raw, line_f;   // [1] clock, [0] data
  logic [DATA_W-1:0] rx_byte;
  logic              rx_par, rx_done, rx_busy;
  logic              tx_busy, tx_clk_drv, tx_data_drv, tx_start;
  logic              wr_ctrl, wr_div, wr_data, rd_data;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[DATA_W-1:CTRL_W];
  assign en       = ctrl_q[C_EN];
  assign line_raw = {ps2_clk_i, ps2_data_i};
  assign fall     = clk_prev && !line_f[1];
  assign wr_ctrl  = reg_en && reg_wr && (reg_addr == A_CTRL);
  assign wr_div   = reg_en && reg_wr && (reg_addr == A_DIV);
  assign wr_data  = reg_en && reg_wr && (reg_addr == A_DATA);
  assign rd_data  = reg_en && !reg_wr && (reg_addr == A_DATA);
  assign tx_start = wr_data && en && !tx_busy;

  ps2hp_tick tick_i (.clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick));

  for (genvar g = 0; g < 2; g++) begin : g_line
    ps2hp_filter #(.FILT_LEN(FILT_LEN)) filt_i (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .line_in(line_raw[g]), .line_out(line_f[g]));
  end

  ps2hp_rx rx_i (
    .clk(clk), .rst_n(rst_n), .active(en && !tx_busy), .fall(fall),
    .line_data(line_f[0]), .rx_byte(rx_byte), .rx_par(rx_par),
    .rx_done(rx_done), .rx_busy(rx_busy));

  ps2hp_tx #(.INHIBIT_TICKS(INHIBIT_TICKS)) tx_i (
    .clk(clk), .rst_n(rst_n), .active(en), .tick(tick), .fall(fall),
    .start(tx_start), .byte_in(reg_wdata), .no_ack(ctrl_q[C_NOACK]),
    .busy(tx_busy), .clk_drv(tx_clk_drv), .data_drv(tx_data_drv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      div_q     <= '0;
      rx_data_q <= '0;
      rx_full_q <= 1'b0;
      rx_par_q  <= 1'b0;
      clk_prev  <= 1'b1;
    end else begin
      clk_prev <= line_f[1];
      if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (wr_div)  div_q  <= reg_wdata[DIV_W-1:0];
      if (rx_done && !rx_full_q) begin
        rx_data_q <= rx_byte;
        rx_par_q  <= rx_par;
        rx_full_q <= 1'b1;
      end else if (rd_data) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  assign ps2_clk_oe  = ctrl_q[C_FCLK] || tx_clk_drv;
  assign ps2_data_oe = ctrl_q[C_FDAT] || tx_data_drv;
  assign irq_rx      = rx_full_q && ctrl_q[C_RXIE];
  assign irq_tx      = !tx_busy && ctrl_q[C_TXIE];

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      A_STAT:  reg_rdata = {1'b0, !tx_busy, tx_busy, rx_full_q, rx_busy,
                            rx_par_q, line_f[1], line_f[0]};
      A_DATA:  reg_rdata = rx_data_q;
      A_DIV:   reg_rdata = {{(DATA_W-DIV_W){1'b0}}, div_q};
      A_IRQ:   reg_rdata = {6'b0, irq_tx, irq_rx};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ps2_host_port_chk.sv
module ps2_host_port_chk
  import ps2hp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl,
  input logic              rx_full,
  input logic              tx_busy,
  input logic              reg_en,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              ps2_clk_oe,
  input logic              ps2_data_oe,
  input logic              irq_rx,
  input logic              irq_tx
);
  p_force_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[C_FCLK] |-> ps2_clk_oe);
  p_force_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[C_FDAT] |-> ps2_data_oe);
  p_clk_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ps2_clk_oe && !ctrl[C_FCLK]) |-> tx_busy);
  p_data_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ps2_data_oe && !ctrl[C_FDAT]) |-> tx_busy);
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && reg_en && !reg_wr && reg_addr == A_DATA) |=> !rx_full);
  p_irq_rx_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> (ctrl[C_RXIE] && rx_full));
  p_irq_tx_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> (ctrl[C_TXIE] && !tx_busy));
  p_disable_idles_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[C_EN] |=> !tx_busy);
endmodule

bind ps2_host_port ps2_host_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .rx_full(rx_full_q),
  .tx_busy(tx_busy), .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ps2_clk_oe(ps2_clk_oe), .ps2_data_oe(ps2_data_oe),
  .irq_rx(irq_rx), .irq_tx(irq_tx));

// File: tb/ps2_host_port_tb_top.sv
module ps2_host_port_tb_top;
  localparam int INH = 16;
  localparam int HP  = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_en = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic ps2_clk_oe, ps2_data_oe, irq_rx, irq_tx;
  logic dev_clk_low = 1'b0, dev_data_low = 1'b0;
  logic line_clk, line_data;
  logic [10:0] got;
  int n_chk = 0, n_fail = 0;

  assign line_clk  = !(ps2_clk_oe || dev_clk_low);
  assign line_data = !(ps2_data_oe || dev_data_low);

  always #10 clk = !clk;

  ps2_host_port #(.INHIBIT_TICKS(INH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ps2_clk_i(line_clk), .ps2_data_i(line_data),
    .ps2_clk_oe(ps2_clk_oe), .ps2_data_oe(ps2_data_oe),
    .irq_rx(irq_rx), .irq_tx(irq_tx));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  task automatic dev_send(input logic [7:0] b, input logic flip, input logic stp);
    logic [10:0] f;
    f = {stp, (~^b) ^ flip, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      dev_data_low = !f[i];
      idle(HP / 2);
      dev_clk_low = 1'b1;
      idle(HP);
      dev_clk_low = 1'b0;
      idle(HP / 2);
    end
    dev_data_low = 1'b0;
    idle(20);
  endtask

  task automatic wait_request();
    while (!(ps2_clk_oe == 1'b0 && ps2_data_oe == 1'b1 && line_clk)) @(negedge clk);
  endtask

  task automatic dev_clock(input int i);
    if (i == 10) dev_data_low = 1'b1;
    idle(HP);
    dev_clk_low = 1'b1;
    idle(HP);
    got[i] = line_data;
    dev_clk_low = 1'b0;
    if (i == 10) begin idle(HP); dev_data_low = 1'b0; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] v, b;
    int n;
    idle(3); rst_n = 1'b1; idle(3);

    // reset state
    rd(3'd1, v); chk("R3 reset status", v, 8'h43);
    chk("R2 reset oe", {ps2_clk_oe, ps2_data_oe}, 0);
    rd(3'd4, v); chk("R10 reset irq", v, 0);

    // forcing lines
    wr(3'd0, 8'h01); chk("R2 force clk", ps2_clk_oe, 1);
    idle(10); rd(3'd1, v); chk("R3 clk level low", v, 8'h41);
    wr(3'd0, 8'h02); chk("R2 force data", {ps2_clk_oe, ps2_data_oe}, 1);
    idle(10); rd(3'd1, v); chk("R3 data level low", v, 8'h42);
    wr(3'd0, 8'h03); idle(10); rd(3'd1, v); chk("R3 both low", v, 8'h40);
    wr(3'd0, 8'h00); idle(10);

    // disabled port
    dev_send(8'h3C, 1'b0, 1'b1);
    rd(3'd1, v); chk("R11 no rx when disabled", v, 8'h43);
    wr(3'd2, 8'h55); idle(30);
    chk("R11 no tx when disabled", ps2_clk_oe, 0);

    // receive sweep
    wr(3'd0, 8'h14);
    for (int i = 0; i < 18; i++) begin
      b = (i == 16) ? 8'h00 : (i == 17) ? 8'hFF : 8'((i * 37 + 11) & 255);
      dev_send(b, 1'b0, 1'b1);
      rd(3'd1, v); chk("R4 full+parity status", v, 8'h53 | ({7'b0, ~^b} << 2));
      chk("R10 irq_rx set", irq_rx, 1);
      rd(3'd4, v); chk("R10 irq reg rx", v, 8'h01);
      rd(3'd2, v); chk("R4 rx byte", v, b);
      rd(3'd1, v); chk("R6 read clears full", v[4], 0);
      chk("R10 irq_rx clear", irq_rx, 0);
    end

    // bad frames
    dev_send(8'h5A, 1'b1, 1'b1);
    rd(3'd1, v); chk("R5 bad parity dropped", v[4], 0);
    dev_send(8'h5A, 1'b0, 1'b0);
    rd(3'd1, v); chk("R5 bad stop dropped", v[4], 0);

    // overflow keeps first byte
    dev_send(8'h11, 1'b0, 1'b1);
    dev_send(8'h22, 1'b0, 1'b1);
    rd(3'd2, v); chk("R6 first byte kept", v, 8'h11);

    // transmit, standard mode
    wr(3'd0, 8'h0C);
    chk("R10 irq_tx idle", irq_tx, 1);
    rd(3'd4, v); chk("R10 irq reg tx", v, 8'h02);
    wr(3'd2, 8'hA6);
    chk("R7 inhibit clock", {ps2_clk_oe, ps2_data_oe}, 2);
    chk("R10 irq_tx busy", irq_tx, 0);
    wait_request();
    wr(3'd2, 8'h3F);
    for (int i = 0; i < 10; i++) dev_clock(i);
    idle(20); rd(3'd1, v); chk("R8 waits for ack", v[6:5], 2'b01);
    dev_clock(10);
    idle(20);
    chk("R7 tx byte", got[7:0], 8'hA6);
    chk("R9 first byte kept", got[7:0], 8'hA6);
    chk("R7 tx parity", got[8], ~^8'hA6);
    chk("R7 tx stop", got[9], 1);
    rd(3'd1, v); chk("R8 done after ack", v[6:5], 2'b10);
    idle(100); chk("R9 no second tx", ps2_clk_oe, 0);

    // transmit, no-acknowledge mode
    wr(3'd0, 8'h24);
    wr(3'd2, 8'h81);
    wait_request();
    for (int i = 0; i < 10; i++) dev_clock(i);
    idle(20);
    rd(3'd1, v); chk("R8 done without ack", v[6:5], 2'b10);
    chk("R7 tx byte no-ack", got[7:0], 8'h81);
    chk("R7 tx parity no-ack", got[8], ~^8'h81);

    // divisor sweep on inhibit length
    for (int d = 0; d < 16; d++) begin
      wr(3'd0, 8'h04);
      wr(3'd3, 8'(d));
      wr(3'd2, 8'h00);
      n = 0;
      while (ps2_clk_oe && !ps2_data_oe && n < 1000) begin n++; @(negedge clk); end
      chk("R1 inhibit length in range",
          (n >= INH * (d + 1) - (d + 1) && n <= INH * (d + 1) + 2) ? 1 : 0, 1);
      wr(3'd0, 8'h00);
      idle(2);
      chk("R11 abort on disable", {ps2_clk_oe, ps2_data_oe}, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule